// File: doc/BRIEF.md
# Dual-Clock Simple Dual-Port RAM

This block is a parameterized memory with one port that only writes and one that only reads. The write side registers its address, data, write enable and per-byte enables on the write clock. One write-clock edge later, it stores the selected bytes of the word. The read side registers its address and read enable on the read clock. On the next read-clock edge, the addressed word is loaded into a registered output.

Each side has its own clock enable and its own active-low asynchronous clear. Each side also has an address-stall input that keeps the address register at the last value it latched. A synchronous clear acts on the output register and on nothing else. A parameter ties the read side to the write clock. In that mode the read-clock pin is ignored, and a same-cycle read and write of one address returns the old word.

Top module: `sdp_ram_2clk`

## Requirements
- R1: With the write enable high at an enabled write-clock edge, the data word is latched with its address. It is stored in memory at the following enabled write-clock edge.
- R2: Bit i of the byte-enable vector selects data bits [8i+7:8i] of the word. Bytes whose enable is 0 keep their old contents.
- R3: A write request with the write enable low leaves the memory unchanged.
- R4: A read enable and address sampled at read-clock edge k put the addressed word on the data output at edge k+1. Back-to-back reads stream one word per cycle.
- R5: When the latched read enable is low, the data output keeps its value.
- R6: While a port's address-stall input is high at an edge, that port's address register keeps its previous value. A write then lands at the previously latched address, and a read returns the word at the previously latched read address. Data and enables still load.
- R7: With the write clock enable low, every write-side register holds and no memory write takes place. With the read clock enable low, the read address, the read enable and the output all hold.
- R8: Driving the write clear low at once zeroes the write-side registers, so a pending write is dropped, and the stored words are kept. Driving the read clear low at once zeroes the read address, the read enable and the output. Neither clear affects the other side.
- R9: The synchronous clear, sampled high at a read-clock edge, sets the output to 0. It does so ahead of any read and whether or not the read clock enable is high.
- R10: In shared-clock mode, a read and a write of the same address presented in the same cycle return the word held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk_i | input | 1 | Write clock; in shared mode also clocks the read side |
| wr_ce_i | input | 1 | Write-side clock enable |
| wr_rst_ni | input | 1 | Write-side asynchronous clear, active low |
| wr_en_i | input | 1 | Write enable |
| wr_addr_stall_i | input | 1 | Keep the latched write address |
| wr_addr_i | input | AW | Write address |
| wr_data_i | input | DW | Write data |
| wr_be_i | input | DW/BW | Byte enables |
| rd_clk_i | input | 1 | Read clock; ignored in shared mode |
| rd_ce_i | input | 1 | Read-side clock enable |
| rd_rst_ni | input | 1 | Read-side asynchronous clear, active low |
| rd_en_i | input | 1 | Read enable |
| rd_addr_stall_i | input | 1 | Keep the latched read address |
| rd_addr_i | input | AW | Read address |
| rd_sclr_i | input | 1 | Synchronous clear of the data output |
| rd_data_o | output | DW | Registered read data |

## Verification
The bench runs a split-clock and a shared-clock instance side by side against one behavioural model. Its main targets are the two-stage write latency, byte merging and the read latency: a design that wrote from unregistered inputs, or read one cycle early, would disagree on streamed reads and on the same-address collision, where the old word must appear. Stall and clock-enable cases also use addresses different from the held ones. A design that let the address through during a stall, or wrote while disabled, would then corrupt a visible word. The clears are checked mid-cycle and across domains: an output that waited for a clock edge to clear, or a write clear that failed to drop a pending write, would be caught.

// File: rtl/sdp_pkg.sv
`timescale 1ns/1ps
package sdp_pkg;
  typedef enum logic {
    CLK_SPLIT  = 1'b0,
    CLK_SHARED = 1'b1
  } clk_mode_e;
endpackage

// File: rtl/sdp_wr_stage.sv
`timescale 1ns/1ps
module sdp_wr_stage #(
  parameter int AW = 5,
  parameter int DW = 32,
  parameter int BW = 8,
  localparam int NB = DW / BW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_i,
  input  logic          stall_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic [NB-1:0] be_i,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output logic [NB-1:0] be_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_o   <= 1'b0;
      addr_o <= '0;
      data_o <= '0;
      be_o   <= '0;
    end else if (ce_i) begin
      if (!stall_i) addr_o <= addr_i;
      we_o   <= we_i;
      data_o <= data_i;
      be_o   <= be_i;
    end
  end

  assert_wr_ce_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> $stable({we_o, addr_o, data_o, be_o}));
  assert_wr_stall_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> $stable(addr_o));
endmodule

// File: rtl/sdp_rd_stage.sv
`timescale 1ns/1ps
module sdp_rd_stage #(
  parameter int AW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_i,
  input  logic          stall_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  output logic          re_o,
  output logic [AW-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      re_o   <= 1'b0;
      addr_o <= '0;
    end else if (ce_i) begin
      if (!stall_i) addr_o <= addr_i;
      re_o <= re_i;
    end
  end

  assert_rd_stall_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> $stable(addr_o));
  assert_rd_ce_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> $stable({re_o, addr_o}));
endmodule

// File: rtl/sdp_mem_core.sv
`timescale 1ns/1ps
module sdp_mem_core #(
  parameter int AW = 5,
  parameter int DW = 32,
  parameter int BW = 8,
  localparam int NB    = DW / BW,
  localparam int DEPTH = 1 << AW
) (
  input  logic          wclk_i,
  input  logic          wce_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [NB-1:0] be_i,
  input  logic          rclk_i,
  input  logic          rrst_ni,
  input  logic          rce_i,
  input  logic          sclr_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] q_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (wce_i && we_i) begin
      for (int b = 0; b < NB; b++) begin
        if (be_i[b]) mem_q[waddr_i][b*BW +: BW] <= wdata_i[b*BW +: BW];
      end
    end
  end

  // sclr wins over a read and ignores the clock enable
  always_ff @(posedge rclk_i or negedge rrst_ni) begin
    if (!rrst_ni)            q_o <= '0;
    else if (sclr_i)         q_o <= '0;
    else if (rce_i && re_i)  q_o <= mem_q[raddr_i];
  end

  assert_sclr_zero_R9: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    sclr_i |=> (q_o == '0));
  assert_q_hold_R5: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    (!sclr_i && !(rce_i && re_i)) |=> $stable(q_o));
endmodule

// File: rtl/sdp_ram_2clk.sv
`timescale 1ns/1ps
module sdp_ram_2clk #(
  parameter int AW = 5,
  parameter int DW = 32,
  parameter int BW = 8,
  parameter sdp_pkg::clk_mode_e CLK_MODE = sdp_pkg::CLK_SPLIT,
  localparam int NB = DW / BW
) (
  input  logic          wr_clk_i,
  input  logic          wr_ce_i,
  input  logic          wr_rst_ni,
  input  logic          wr_en_i,
  input  logic          wr_addr_stall_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [NB-1:0] wr_be_i,
  input  logic          rd_clk_i,
  input  logic          rd_ce_i,
  input  logic          rd_rst_ni,
  input  logic          rd_en_i,
  input  logic          rd_addr_stall_i,
  input  logic [AW-1:0] rd_addr_i,
  input  logic          rd_sclr_i,
  output logic [DW-1:0] rd_data_o
);
  logic          rd_clk;
  logic          w_we;
  logic [AW-1:0] w_addr;
  logic [DW-1:0] w_data;
  logic [NB-1:0] w_be;
  logic          r_re;
  logic [AW-1:0] r_addr;

  if (CLK_MODE == sdp_pkg::CLK_SHARED) begin : g_shared
    logic unused_rd_clk;
    assign unused_rd_clk = rd_clk_i;
    assign rd_clk = wr_clk_i;
  end else begin : g_split
    assign rd_clk = rd_clk_i;
  end

  sdp_wr_stage #(.AW(AW), .DW(DW), .BW(BW)) u_wr (
    .clk_i  (wr_clk_i),
    .rst_ni (wr_rst_ni),
    .ce_i   (wr_ce_i),
    .stall_i(wr_addr_stall_i),
    .we_i   (wr_en_i),
    .addr_i (wr_addr_i),
    .data_i (wr_data_i),
    .be_i   (wr_be_i),
    .we_o   (w_we),
    .addr_o (w_addr),
    .data_o (w_data),
    .be_o   (w_be)
  );

  sdp_rd_stage #(.AW(AW)) u_rd (
    .clk_i  (rd_clk),
    .rst_ni (rd_rst_ni),
    .ce_i   (rd_ce_i),
    .stall_i(rd_addr_stall_i),
    .re_i   (rd_en_i),
    .addr_i (rd_addr_i),
    .re_o   (r_re),
    .addr_o (r_addr)
  );

  sdp_mem_core #(.AW(AW), .DW(DW), .BW(BW)) u_mem (
    .wclk_i (wr_clk_i),
    .wce_i  (wr_ce_i),
    .we_i   (w_we),
    .waddr_i(w_addr),
    .wdata_i(w_data),
    .be_i   (w_be),
    .rclk_i (rd_clk),
    .rrst_ni(rd_rst_ni),
    .rce_i  (rd_ce_i),
    .sclr_i (rd_sclr_i),
    .re_i   (r_re),
    .raddr_i(r_addr),
    .q_o    (rd_data_o)
  );
endmodule

// File: tb/sim_sdp_ram_2clk.sv
`timescale 1ns/1ps
module sim_sdp_ram_2clk;
  localparam int AW = 5, DW = 32, BW = 8, NB = DW / BW, DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          wr_ce = 1'b1, wr_rst_n = 1'b0, wr_en = 1'b0, wr_stall = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [NB-1:0] wr_be = '0;
  logic          rd_ce = 1'b1, rd_rst_n = 1'b0, rd_en = 1'b0, rd_stall = 1'b0, sclr = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] q0, q1;

  int n_vec = 0;
  int n_bad = 0;

  sdp_ram_2clk #(.AW(AW), .DW(DW), .BW(BW), .CLK_MODE(sdp_pkg::CLK_SPLIT)) u0 (
    .wr_clk_i(clk), .wr_ce_i(wr_ce), .wr_rst_ni(wr_rst_n), .wr_en_i(wr_en),
    .wr_addr_stall_i(wr_stall), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .wr_be_i(wr_be),
    .rd_clk_i(clk), .rd_ce_i(rd_ce), .rd_rst_ni(rd_rst_n), .rd_en_i(rd_en),
    .rd_addr_stall_i(rd_stall), .rd_addr_i(rd_addr), .rd_sclr_i(sclr), .rd_data_o(q0)
  );

  sdp_ram_2clk #(.AW(AW), .DW(DW), .BW(BW), .CLK_MODE(sdp_pkg::CLK_SHARED)) u1 (
    .wr_clk_i(clk), .wr_ce_i(wr_ce), .wr_rst_ni(wr_rst_n), .wr_en_i(wr_en),
    .wr_addr_stall_i(wr_stall), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .wr_be_i(wr_be),
    .rd_clk_i(1'b0), .rd_ce_i(rd_ce), .rd_rst_ni(rd_rst_n), .rd_en_i(rd_en),
    .rd_addr_stall_i(rd_stall), .rd_addr_i(rd_addr), .rd_sclr_i(sclr), .rd_data_o(q1)
  );

  // behavioural reference, one update per clock
  logic [DW-1:0] m_mem [DEPTH];
  logic [AW-1:0] m_waddr = '0, m_raddr = '0;
  logic [DW-1:0] m_wdata = '0, m_q = '0;
  logic          m_wen = 1'b0, m_ren = 1'b0;
  logic [NB-1:0] m_be = '0;

  always @(posedge clk) begin
    logic [DW-1:0] old_word;
    old_word = m_mem[m_raddr];
    if (!rd_rst_n) begin
      m_raddr = '0; m_ren = 1'b0; m_q = '0;
    end else begin
      if (sclr) m_q = '0;
      else if (rd_ce && m_ren) m_q = old_word;
      if (rd_ce) begin
        if (!rd_stall) m_raddr = rd_addr;
        m_ren = rd_en;
      end
    end
    if (!wr_rst_n) begin
      m_waddr = '0; m_wdata = '0; m_wen = 1'b0; m_be = '0;
    end else if (wr_ce) begin
      if (m_wen)
        for (int b = 0; b < NB; b++)
          if (m_be[b]) m_mem[m_waddr][b*BW +: BW] = m_wdata[b*BW +: BW];
      if (!wr_stall) m_waddr = wr_addr;
      m_wdata = wr_data; m_wen = wr_en; m_be = wr_be;
    end
  end

  task automatic check(input string req);
    n_vec++;
    if (q0 !== m_q) begin
      n_bad++;
      $display("FAIL %s split q=%h expected %h", req, q0, m_q);
    end
    n_vec++;
    if (q1 !== m_q) begin
      n_bad++;
      $display("FAIL %s shared q=%h expected %h", req, q1, m_q);
    end
  endtask

  task automatic tick(input string req);
    @(posedge clk);
    @(negedge clk);
    check(req);
  endtask

  task automatic set_w(input logic en, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic [NB-1:0] be);
    wr_en = en; wr_addr = a; wr_data = d; wr_be = be;
  endtask

  task automatic set_r(input logic en, input logic [AW-1:0] a);
    rd_en = en; rd_addr = a;
  endtask

  function automatic logic [DW-1:0] pat(input int a);
    return 32'hA500_0000 ^ (32'h0101_0101 * (a + 1));
  endfunction

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    tick("R8"); tick("R8");
    wr_rst_n = 1'b1; rd_rst_n = 1'b1;
    tick("R8");

    for (int a = 0; a < DEPTH; a++) begin set_w(1, a[AW-1:0], pat(a), '1); tick("R1"); end
    set_w(0, 0, 0, 0); tick("R1");
    for (int a = 0; a < DEPTH; a++) begin set_r(1, a[AW-1:0]); tick("R4"); end
    set_r(0, 0); tick("R4"); tick("R4");

    set_w(1, 3, 32'hFFFF_FFFF, 4'b0101); tick("R2");
    set_w(0, 0, 0, 0); set_r(1, 3); tick("R2");
    set_r(0, 0); tick("R2"); tick("R2");

    set_w(0, 4, 32'h1234_5678, '1); tick("R3");
    set_w(0, 0, 0, 0); tick("R3");
    set_r(1, 4); tick("R3"); set_r(0, 0); tick("R3"); tick("R3");

    set_r(1, 5); tick("R5");
    set_r(0, 9); tick("R5"); tick("R5"); tick("R5");

    set_w(1, 7, 32'hC0DE_0007, '1); tick("R6");
    wr_stall = 1'b1; set_w(1, 9, 32'hBAD0_0009, '1); tick("R6");
    wr_stall = 1'b0; set_w(0, 0, 0, 0); tick("R6"); tick("R6");
    set_r(1, 7); tick("R6"); set_r(1, 9); tick("R6"); set_r(0, 0); tick("R6"); tick("R6");
    set_r(1, 12); tick("R6");
    rd_stall = 1'b1; set_r(1, 13); tick("R6"); tick("R6");
    rd_stall = 1'b0; set_r(0, 0); tick("R6"); tick("R6");

    wr_ce = 1'b0; set_w(1, 14, 32'hDEAD_000E, '1); tick("R7"); tick("R7");
    set_w(0, 0, 0, 0); wr_ce = 1'b1; tick("R7"); tick("R7");
    set_r(1, 14); tick("R7");
    rd_ce = 1'b0; set_r(1, 2); tick("R7"); tick("R7");
    rd_ce = 1'b1; set_r(0, 0); tick("R7"); tick("R7");

    set_r(1, 20); tick("R9");
    sclr = 1'b1; tick("R9");
    sclr = 1'b0; tick("R9");
    rd_ce = 1'b0; sclr = 1'b1; tick("R9");
    sclr = 1'b0; rd_ce = 1'b1; set_r(0, 0); tick("R9"); tick("R9");

    set_w(1, 21, 32'h5555_AAAA, '1); set_r(1, 21); tick("R10");
    set_w(0, 0, 0, 0); tick("R10");
    set_r(0, 0); tick("R10"); tick("R10");

    set_r(1, 22); tick("R8"); tick("R8");
    rd_rst_n = 1'b0;
    #1;
    n_vec++;
    if (q0 !== '0 || q1 !== '0) begin
      n_bad++;
      $display("FAIL R8 async read clear q=%h/%h expected 0", q0, q1);
    end
    set_r(0, 0); tick("R8");
    rd_rst_n = 1'b1; tick("R8");

    set_w(1, 23, 32'h0BAD_0017, '1); tick("R8");
    wr_rst_n = 1'b0; set_w(0, 0, 0, 0); set_r(1, 23);
    tick("R8"); tick("R8");
    wr_rst_n = 1'b1; set_r(1, 23); tick("R8");
    set_r(0, 0); tick("R8"); tick("R8");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule